// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes one accept-or-drop decision for every received frame. When a frame ends, the MAC presents the destination address, the VLAN tag details and the error flags it collected during the frame, and pulses a frame-end strobe. The filter checks the address against sixteen programmable exact-match slots, a 4096-bit multicast hash table and two promiscuous modes. It can also require a set bit in a per-VLAN-ID table, and it applies a policy for damaged frames. One clock later it reports the decision, a reason code and the error flags to keep with the frame.

Settings arrive through a narrow write port. Each write targets one of four things: a slot (address plus valid bit), one hash-table bit, one VLAN-table bit, or the mode word. A write that arrives in the same cycle as a frame-end strobe is dropped. The frame being judged therefore always sees a consistent set of settings.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, decValid is low, every slot is invalid, both tables are all zero and every mode bit is clear, so any frame is rejected.
- R2: A frame whose 48-bit destination equals the address of a valid slot is accepted with reason 1 (exact). This holds for unicast and multicast addresses alike. An exact hit takes priority over every other address rule.
- R3: A slot written with cfgBit=0 is invalid and never matches, even if its address equals the destination.
- R4: With mode bit 0 (promiscuous unicast) set, any unicast destination (frmDa[0]=0) without an exact hit is accepted with reason 3.
- R5: A multicast destination (frmDa[0]=1) without an exact hit is accepted with reason 2 (hash) when promiscuous multicast is off and the hash-table bit it indexes is 1. The index is a 12-bit address window selected by mode bits [5:4]: 0 gives frmDa[47:36], 1 gives [46:35], 2 gives [45:34] and 3 gives [43:32]. If that bit is 0, the frame is rejected.
- R6: With mode bit 1 (promiscuous multicast) set, any multicast destination without an exact hit is accepted with reason 4. The all-ones broadcast address counts as multicast unless a slot holds it.
- R7: With mode bit 3 (VLAN filter) set, a tagged frame is accepted with reason 5 only if its address passes the rules above and the VLAN-table bit at frmVid is 1. Otherwise it is rejected. Untagged frames follow the address rules alone.
- R8: A frame with any frmErr bit set is rejected unless mode bit 2 (store bad) is set. The error bits are: bit 0 CRC, 1 symbol, 2 sequence, 3 length, 4 alignment, 5 carrier extension or receive error. With store bad set, the frame is judged on its address alone. On acceptance decErr carries frmErr; on rejection decErr is 0.
- R9: decValid is a single-cycle pulse in the cycle after each frmEnd cycle. Back-to-back frame ends give back-to-back decisions. A rejected frame reports reason 0.
- R10: A configuration write made in a cycle where frmEnd is high has no effect. A write with frmEnd low takes effect for frames ending in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Write target: 0 slot, 1 hash bit, 2 VLAN bit, 3 mode word |
| cfgIndex | input | 12 | Slot number (low 4 bits) or table bit index |
| cfgData | input | 48 | Slot address, or mode word in bits [5:0] |
| cfgBit | input | 1 | Slot valid bit or table bit value |
| frmEnd | input | 1 | Frame-end strobe; frame fields are valid in this cycle |
| frmDa | input | 48 | Destination address, first transmitted byte in bits [7:0] |
| frmTagged | input | 1 | Frame carries a VLAN tag |
| frmVid | input | 12 | VLAN ID of a tagged frame |
| frmErr | input | 6 | Per-frame error flags |
| decValid | output | 1 | Decision pulse |
| decAccept | output | 1 | Frame accepted |
| decReason | output | 3 | 0 reject, 1 exact, 2 hash, 3 promiscuous unicast, 4 promiscuous multicast, 5 VLAN |
| decErr | output | 6 | Error flags forwarded with an accepted frame |

## Verification
The two functions that can meet in one cycle are a settings write and a frame-end judgement. The bench drives a write and a frame end in the same cycle, both on its own and with writes that would change the outcome of that frame or of the next. Writing a slot in that cycle, then sending a frame to that slot's address, must still give a reject, since the write was dropped. The same frame is accepted once the write is repeated in a quiet cycle. A behavioural model of the settings, updated with the same drop rule, predicts every decision and is compared with the outputs on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Decision reason codes
  typedef enum logic [2:0] {
    RSN_REJECT  = 3'd0,
    RSN_EXACT   = 3'd1,
    RSN_HASH    = 3'd2,
    RSN_PROM_UC = 3'd3,
    RSN_PROM_MC = 3'd4,
    RSN_VLAN    = 3'd5
  } rsn_e;

  // Configuration write targets
  typedef enum logic [1:0] {
    TGT_EXACT = 2'd0,
    TGT_HASH  = 2'd1,
    TGT_VLAN  = 2'd2,
    TGT_MODE  = 2'd3
  } tgt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrExact;
    logic wrHash;
    logic wrVlan;
    logic wrMode;
    logic capture;
  } strobe_t;

  // Mode word, bit 0 is promUc
  typedef struct packed {
    logic [1:0] hashSel;
    logic       vlanEn;
    logic       storeBad;
    logic       promMc;
    logic       promUc;
  } mode_t;

endpackage

// File: rtl/rxf_exact_cam.sv
module rxf_exact_cam #(
  parameter  int SLOTS  = 16,
  parameter  int ADDR_W = 48,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              hit
);

  logic [SLOTS-1:0] slotMatch;

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic [ADDR_W-1:0] slotAddr;
    logic              slotValid;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr  <= '0;
        slotValid <= 1'b0;
      end else if (wrEn && (wrSlot == SLOT_W'(g))) begin
        slotAddr  <= wrAddr;
        slotValid <= wrValid;
      end
    end

    assign slotMatch[g] = slotValid && (slotAddr == lookAddr);
  end

  assign hit = |slotMatch;

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter  int SLOTS  = 16,
  parameter  int ADDR_W = 48,
  parameter  int IDX_W  = 12,
  parameter  int ERR_W  = 6,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int DEPTH  = 1 << IDX_W,
  localparam int MODE_W = $bits(mode_t)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  cfgIndex,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cfgBit,
  input  logic [ADDR_W-1:0] frmDa,
  input  logic              frmTagged,
  input  logic [IDX_W-1:0]  frmVid,
  input  logic [ERR_W-1:0]  frmErr,
  output logic              decAccept,
  output logic [2:0]        decReason,
  output logic [ERR_W-1:0]  decErr
);

  mode_t            modeReg;
  logic [DEPTH-1:0] hashTab;
  logic [DEPTH-1:0] vlanTab;

  // Settings storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      hashTab <= '0;
      vlanTab <= '0;
    end else begin
      if (stb.wrMode) modeReg <= mode_t'(cfgData[MODE_W-1:0]);
      if (stb.wrHash) hashTab[cfgIndex] <= cfgBit;
      if (stb.wrVlan) vlanTab[cfgIndex] <= cfgBit;
    end
  end

  // Exact-match slots
  logic exactHit;

  rxf_exact_cam #(
    .SLOTS  (SLOTS),
    .ADDR_W (ADDR_W)
  ) cam_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (stb.wrExact),
    .wrSlot   (cfgIndex[SLOT_W-1:0]),
    .wrAddr   (cfgData),
    .wrValid  (cfgBit),
    .lookAddr (frmDa),
    .hit      (exactHit)
  );

  // Hash index window
  logic [IDX_W-1:0] hashIdx;
  always_comb begin
    unique case (modeReg.hashSel)
      2'd0:    hashIdx = frmDa[ADDR_W-1 -: IDX_W];
      2'd1:    hashIdx = frmDa[ADDR_W-2 -: IDX_W];
      2'd2:    hashIdx = frmDa[ADDR_W-3 -: IDX_W];
      default: hashIdx = frmDa[ADDR_W-5 -: IDX_W];
    endcase
  end

  logic isMc;
  logic frmBad;
  assign isMc   = frmDa[0];
  assign frmBad = |frmErr;

  rsn_e addrRsn;
  rsn_e finalRsn;

  always_comb begin
    if (exactHit)
      addrRsn = RSN_EXACT;
    else if (isMc) begin
      if (modeReg.promMc)        addrRsn = RSN_PROM_MC;
      else if (hashTab[hashIdx]) addrRsn = RSN_HASH;
      else                       addrRsn = RSN_REJECT;
    end else
      addrRsn = modeReg.promUc ? RSN_PROM_UC : RSN_REJECT;

    finalRsn = addrRsn;
    if (modeReg.vlanEn && frmTagged)
      finalRsn = ((addrRsn != RSN_REJECT) && vlanTab[frmVid]) ? RSN_VLAN : RSN_REJECT;
    if (frmBad && !modeReg.storeBad)
      finalRsn = RSN_REJECT;
  end

  // Registered decision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decAccept <= 1'b0;
      decReason <= RSN_REJECT;
      decErr    <= '0;
    end else if (stb.capture) begin
      decAccept <= (finalRsn != RSN_REJECT);
      decReason <= finalRsn;
      decErr    <= (finalRsn != RSN_REJECT) ? frmErr : '0;
    end
  end

  // R10
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> $stable(modeReg));

  // R10
  hash_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> $stable(hashTab));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.capture) && !decAccept |-> decErr == '0);

endmodule

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic       frmEnd,
  output strobe_t    stb,
  output logic       decValid
);

  logic wrOk;
  assign wrOk = cfgWrEn && !frmEnd;

  always_comb begin
    stb         = '0;
    stb.capture = frmEnd;
    if (wrOk) begin
      unique case (tgt_e'(cfgSel))
        TGT_EXACT: stb.wrExact = 1'b1;
        TGT_HASH:  stb.wrHash  = 1'b1;
        TGT_VLAN:  stb.wrVlan  = 1'b1;
        default:   stb.wrMode  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decValid <= 1'b0;
    else       decValid <= frmEnd;
  end

  // R9
  dec_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmEnd |=> decValid);

  // R9
  dec_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frmEnd |=> !decValid);

  // R10
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrExact, stb.wrHash, stb.wrVlan, stb.wrMode}));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 12,
  parameter int ERR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIndex,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cfgBit,
  input  logic              frmEnd,
  input  logic [ADDR_W-1:0] frmDa,
  input  logic              frmTagged,
  input  logic [IDX_W-1:0]  frmVid,
  input  logic [ERR_W-1:0]  frmErr,
  output logic              decValid,
  output logic              decAccept,
  output logic [2:0]        decReason,
  output logic [ERR_W-1:0]  decErr
);

  strobe_t stb;

  rxf_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .frmEnd   (frmEnd),
    .stb      (stb),
    .decValid (decValid)
  );

  rxf_datapath #(
    .SLOTS  (SLOTS),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .ERR_W  (ERR_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgIndex  (cfgIndex),
    .cfgData   (cfgData),
    .cfgBit    (cfgBit),
    .frmDa     (frmDa),
    .frmTagged (frmTagged),
    .frmVid    (frmVid),
    .frmErr    (frmErr),
    .decAccept (decAccept),
    .decReason (decReason),
    .decErr    (decErr)
  );

endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgSel;
  logic [11:0] cfgIndex;
  logic [47:0] cfgData;
  logic        cfgBit;
  logic        frmEnd;
  logic [47:0] frmDa;
  logic        frmTagged;
  logic [11:0] frmVid;
  logic [5:0]  frmErr;
  logic        decValid;
  logic        decAccept;
  logic [2:0]  decReason;
  logic [5:0]  decErr;

  always #10 clk = ~clk;

  rx_addr_filter dut_i (
    .clk, .rstN, .cfgWrEn, .cfgSel, .cfgIndex, .cfgData, .cfgBit,
    .frmEnd, .frmDa, .frmTagged, .frmVid, .frmErr,
    .decValid, .decAccept, .decReason, .decErr
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural model of settings
  logic [47:0] mAddr [16];
  bit          mVal  [16];
  bit          mHash [4096];
  bit          mVlan [4096];
  bit          mPromUc, mPromMc, mBad, mVlanEn;
  int          mSel;
  bit          expValid = 1'b0;
  int          expReason = 0;
  logic [5:0]  expErr = '0;

  function automatic int win(logic [47:0] da, int s);
    case (s)
      0:       return int'(da[47:36]);
      1:       return int'(da[46:35]);
      2:       return int'(da[45:34]);
      default: return int'(da[43:32]);
    endcase
  endfunction

  function automatic int refReason(logic [47:0] da, bit tag, int vid, logic [5:0] err);
    int r;
    bit hit;
    r = 0;
    hit = 1'b0;
    for (int i = 0; i < 16; i++) if (mVal[i] && mAddr[i] == da) hit = 1'b1;
    if (hit) r = 1;
    else if (da[0]) begin
      if (mPromMc) r = 4;
      else if (mHash[win(da, mSel)]) r = 2;
    end else if (mPromUc) r = 3;
    if (mVlanEn && tag) r = (r != 0 && mVlan[vid]) ? 5 : 0;
    if (err != 0 && !mBad) r = 0;
    return r;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: compare, drive, advance model, move to next negedge
  task automatic step(bit wr, int sel, int idx, logic [47:0] data, bit b,
                      bit fe, logic [47:0] da, bit tag, int vid, logic [5:0] err);
    chk("R9", "decValid", int'(decValid), int'(expValid));
    if (expValid) begin
      chk("R9", "model accept", int'(decAccept), int'(expReason != 0));
      chk("R9", "model reason", int'(decReason), expReason);
      chk("R8", "model err", int'(decErr), (expReason != 0) ? int'(expErr) : 0);
    end
    cfgWrEn = wr; cfgSel = 2'(sel); cfgIndex = 12'(idx); cfgData = data; cfgBit = b;
    frmEnd = fe; frmDa = da; frmTagged = tag; frmVid = 12'(vid); frmErr = err;
    expValid = fe;
    if (fe) begin
      expReason = refReason(da, tag, vid, err);
      expErr = err;
    end
    if (wr && !fe) begin
      case (sel)
        0: begin mAddr[idx % 16] = data; mVal[idx % 16] = b; end
        1: mHash[idx] = b;
        2: mVlan[idx] = b;
        default: begin
          mPromUc = data[0]; mPromMc = data[1]; mBad = data[2];
          mVlanEn = data[3]; mSel = int'(data[5:4]);
        end
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, 0, '0, 0, 0, '0);
  endtask
  task automatic wrSlot(int s, logic [47:0] a, bit v);
    step(1, 0, s, a, v, 0, '0, 0, 0, '0);
  endtask
  task automatic wrHash(int i, bit v);
    step(1, 1, i, '0, v, 0, '0, 0, 0, '0);
  endtask
  task automatic wrVlan(int i, bit v);
    step(1, 2, i, '0, v, 0, '0, 0, 0, '0);
  endtask
  task automatic wrMode(bit pu, bit pm, bit sb, bit ve, int s);
    step(1, 3, 0, {42'd0, 2'(s), ve, sb, pm, pu}, 0, 0, '0, 0, 0, '0);
  endtask
  task automatic fchk(logic [47:0] da, bit tag, int vid, logic [5:0] err,
                      bit acc, int rsn, string req);
    step(0, 0, 0, '0, 0, 1, da, tag, vid, err);
    chk(req, "decValid", int'(decValid), 1);
    chk(req, "accept", int'(decAccept), int'(acc));
    chk(req, "reason", int'(decReason), rsn);
  endtask

  localparam logic [47:0] UA = 48'h6655_4433_2210;
  localparam logic [47:0] UB = 48'h0102_0304_0506;
  localparam logic [47:0] MA = 48'h0000_5E00_0001;
  localparam logic [47:0] HD = 48'h9C5A_3F71_2E01;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UE = 48'hABCD_EF01_2340;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    cfgWrEn = 0; cfgSel = 0; cfgIndex = 0; cfgData = 0; cfgBit = 0;
    frmEnd = 0; frmDa = 0; frmTagged = 0; frmVid = 0; frmErr = 0;
    mPromUc = 0; mPromMc = 0; mBad = 0; mVlanEn = 0; mSel = 0;
    for (int i = 0; i < 16; i++) begin mAddr[i] = '0; mVal[i] = 0; end
    for (int i = 0; i < 4096; i++) begin mHash[i] = 0; mVlan[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "decValid in reset", int'(decValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: everything rejected after reset
    fchk(UA, 0, 0, '0, 0, 0, "R1");
    fchk(BC, 0, 0, '0, 0, 0, "R1");

    // R2: exact unicast and multicast
    wrSlot(5, UA, 1);
    fchk(UA, 0, 0, '0, 1, 1, "R2");
    fchk(UB, 0, 0, '0, 0, 0, "R2");
    wrSlot(15, MA, 1);
    fchk(MA, 0, 0, '0, 1, 1, "R2");

    // R3: invalidated slot
    wrSlot(5, UA, 0);
    fchk(UA, 0, 0, '0, 0, 0, "R3");

    // R4: promiscuous unicast
    wrMode(1, 0, 0, 0, 0);
    fchk(UB, 0, 0, '0, 1, 3, "R4");
    fchk(HD, 0, 0, '0, 0, 0, "R5");

    // R5: each hash window
    for (int s = 0; s < 4; s++) begin
      wrMode(0, 0, 0, 0, s);
      wrHash(win(HD, s), 1);
      fchk(HD, 0, 0, '0, 1, 2, "R5");
      wrHash(win(HD, s), 0);
      fchk(HD, 0, 0, '0, 0, 0, "R5");
    end

    // R6: promiscuous multicast, broadcast
    wrMode(0, 1, 0, 0, 0);
    fchk(BC, 0, 0, '0, 1, 4, "R6");
    fchk(UB, 0, 0, '0, 0, 0, "R6");
    wrSlot(2, BC, 1);
    fchk(BC, 0, 0, '0, 1, 1, "R2");
    fchk(MA, 0, 0, '0, 1, 1, "R2");

    // R7: VLAN table
    wrSlot(5, UA, 1);
    wrMode(0, 0, 0, 1, 0);
    fchk(UA, 1, 100, '0, 0, 0, "R7");
    wrVlan(100, 1);
    fchk(UA, 1, 100, '0, 1, 5, "R7");
    fchk(UB, 1, 100, '0, 0, 0, "R7");
    fchk(UA, 0, 7, '0, 1, 1, "R7");

    // R8: bad frames
    wrMode(0, 0, 0, 0, 0);
    fchk(UA, 0, 0, 6'b000001, 0, 0, "R8");
    fchk(UA, 0, 0, 6'b100000, 0, 0, "R8");
    wrMode(0, 0, 1, 0, 0);
    fchk(UA, 0, 0, 6'b010010, 1, 1, "R8");
    chk("R8", "forwarded err", int'(decErr), 18);
    fchk(UB, 0, 0, 6'b000100, 0, 0, "R8");
    chk("R8", "err on reject", int'(decErr), 0);

    // R10: write during frame end is dropped
    step(1, 0, 3, UE, 1, 1, UE, 0, 0, '0);
    chk("R10", "same-cycle frame", int'(decAccept), 0);
    fchk(UE, 0, 0, '0, 0, 0, "R10");
    step(1, 3, 0, 48'h2, 0, 1, UB, 0, 0, '0);
    fchk(BC, 0, 0, '0, 1, 1, "R10");
    fchk(HD, 0, 0, '0, 0, 0, "R10");
    wrSlot(3, UE, 1);
    fchk(UE, 0, 0, '0, 1, 1, "R10");

    // R9: pulse and back-to-back
    idle();
    chk("R9", "quiet", int'(decValid), 0);
    fchk(UA, 0, 0, '0, 1, 1, "R9");
    fchk(UB, 0, 0, '0, 0, 0, "R9");
    idle();
    chk("R9", "pulse ends", int'(decValid), 0);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule